// File: doc/BRIEF.md
# Burst DMA Channel Transfer Engine

This block is the data-moving core of one DMA channel. A launch pulse captures a source address, a destination address, a byte count, a burst-size code and per-side addressing and pacing settings. The engine then copies 32-bit words from source to destination over a simple synchronous memory master port: one read, then the matching write one cycle later.

Each side can be held at a fixed address so that it serves a peripheral FIFO. A side whose request code names a peripheral line waits for that line to be high before every burst. That side receives a one-cycle acknowledge after the burst's last write. A side whose code marks plain memory never waits. A software-mode launch ignores all request lines. When the word count runs out, busy falls and done pulses for one cycle. A synchronous abort ends the job at the next word boundary without a done pulse.

Top module: `dma_burst_engine`

## Requirements
- R1: Every beat moves one 32-bit word. A read is issued in one cycle and the word it returns is written, unchanged, in the next cycle. A read and a write never occur in the same cycle.
- R2: The burst-size code gives the words per burst: 0→1, 1→2, 2→4, 3→8, 4→16. Codes 5 to 7 are treated as 16 words.
- R3: The byte count is 16 bits wide. A job moves ceil(count/4) words. The last burst is cut to the words that remain, so no extra word is ever read or written.
- R4: A side with its fixed bit set keeps its address for the whole job. A side without it steps by 4 bytes after each word.
- R5: In software mode no request line is consulted and no acknowledge is raised.
- R6: Request codes 0 to NREQ-1 (31 by default) select a peripheral line that must be high before each burst of that side starts. Codes of NREQ (32) and above mark the side as memory, which never waits.
- R7: A paced side gets a one-cycle pulse on its own acknowledge line in the cycle after the last write of each burst.
- R8: After the final write, busy is low and done is high for exactly one cycle, both in the cycle that follows that write.
- R9: A launch that arrives while busy is high is ignored and leaves the running job unchanged.
- R10: A byte count of zero raises done in the cycle after the launch. It performs no memory access, and busy stays low.
- R11: Abort stops the job once the current word has been written, or at once if no word is in flight. Busy then falls and no done pulse is raised. A job whose final word is being written when abort arrives still completes normally.
- R12: After reset, busy, done, both memory enables and all acknowledge lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch | input | 1 | Start pulse; the settings below are captured with it |
| abort | input | 1 | Synchronous stop request |
| cfg_src_addr | input | AW | Source byte address |
| cfg_dst_addr | input | AW | Destination byte address |
| cfg_len | input | LENW | Byte count |
| cfg_burst | input | 3 | Burst-size code |
| cfg_src_fixed | input | 1 | Hold the source address |
| cfg_dst_fixed | input | 1 | Hold the destination address |
| cfg_sw_mode | input | 1 | Run without any handshake |
| cfg_src_req | input | REQW | Source request code |
| cfg_dst_req | input | REQW | Destination request code |
| periph_req | input | NREQ | Peripheral request lines |
| periph_ack | output | NREQ | Peripheral acknowledge pulses |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read byte address |
| mem_rd_data | input | 32 | Read data, valid the cycle after mem_rd_en |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write byte address |
| mem_wr_data | output | 32 | Memory write data |

## Verification
With every paced line ready, the first read appears two cycles after the launch edge. Each write follows its read by one cycle, and acknowledge and done appear in the cycle after the final write. A zero-length done appears in the cycle right after the launch. The bench drives inputs on falling edges and reads outputs on the next falling edge, so every one-cycle pulse is seen in its due cycle. Job results are judged from counters updated on rising edges and from the bench's own memory once done has been seen. Stall, ignore and abort cases are checked after a fixed wait of several cycles, so that any late access would be counted.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } eng_state_e;

    localparam int BURST_CODE_W  = 3;
    localparam int MAX_BURST_LOG = 4;
    localparam int BEAT_W        = MAX_BURST_LOG + 1;
endpackage

// File: rtl/dma_burst_sizer.sv
module dma_burst_sizer
    import dma_burst_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic [BURST_CODE_W-1:0] code,
    input  logic [CNT_W-1:0]        rem_words,
    output logic [BEAT_W-1:0]       burst_words
);
    logic [BURST_CODE_W-1:0] lg;
    logic [CNT_W-1:0]        cap;

    always_comb begin
        lg  = (code > BURST_CODE_W'(MAX_BURST_LOG)) ? BURST_CODE_W'(MAX_BURST_LOG) : code;
        cap = CNT_W'(1) << lg;
        burst_words = (rem_words < cap) ? BEAT_W'(rem_words) : BEAT_W'(cap);
    end
endmodule

// File: rtl/dma_pace_side.sv
module dma_pace_side #(
    parameter int NREQ = 32,
    parameter int REQW = 6
) (
    input  logic            sw_mode,
    input  logic [REQW-1:0] code,
    input  logic [NREQ-1:0] periph_req,
    output logic            ready,
    output logic [NREQ-1:0] ack_sel
);
    logic paced;

    always_comb begin
        paced = !sw_mode && (code < REQW'(NREQ));
        for (int i = 0; i < NREQ; i++) begin
            ack_sel[i] = paced && (code == REQW'(i));
        end
        ready = !paced || (|(ack_sel & periph_req));
    end
endmodule

// File: rtl/dma_burst_engine.sv
module dma_burst_engine
    import dma_burst_pkg::*;
#(
    parameter int AW   = 32,
    parameter int LENW = 16,
    parameter int NREQ = 32,
    parameter int REQW = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    launch,
    input  logic                    abort,
    input  logic [AW-1:0]           cfg_src_addr,
    input  logic [AW-1:0]           cfg_dst_addr,
    input  logic [LENW-1:0]         cfg_len,
    input  logic [BURST_CODE_W-1:0] cfg_burst,
    input  logic                    cfg_src_fixed,
    input  logic                    cfg_dst_fixed,
    input  logic                    cfg_sw_mode,
    input  logic [REQW-1:0]         cfg_src_req,
    input  logic [REQW-1:0]         cfg_dst_req,
    input  logic [NREQ-1:0]         periph_req,
    output logic [NREQ-1:0]         periph_ack,
    output logic                    busy,
    output logic                    done,
    output logic                    mem_rd_en,
    output logic [AW-1:0]           mem_rd_addr,
    input  logic [31:0]             mem_rd_data,
    output logic                    mem_wr_en,
    output logic [AW-1:0]           mem_wr_addr,
    output logic [31:0]             mem_wr_data
);
    localparam int WCW    = LENW - 1;
    localparam int NSIDES = 2;

    typedef struct packed {
        eng_state_e              st;
        logic [AW-1:0]           src;
        logic [AW-1:0]           dst;
        logic [WCW-1:0]          rem;
        logic [BEAT_W-1:0]       beat;
        logic [BURST_CODE_W-1:0] bcode;
        logic                    sf;
        logic                    df;
        logic                    sw;
        logic [REQW-1:0]         sreq;
        logic [REQW-1:0]         dreq;
        logic                    abort_pend;
        logic                    done;
        logic [NREQ-1:0]         ack;
    } eng_s;

    eng_s q, d;

    logic [LENW:0]                 len_ext;
    logic [WCW-1:0]                launch_words;
    logic [BEAT_W-1:0]             next_burst;
    logic [REQW-1:0]               side_code [NSIDES];
    logic [NSIDES-1:0]             side_ready;
    logic [NSIDES-1:0][NREQ-1:0]   side_ack;
    logic [NREQ-1:0]               ack_all;

    assign side_code[0] = q.sreq;
    assign side_code[1] = q.dreq;

    for (genvar s = 0; s < NSIDES; s++) begin : g_side
        dma_pace_side #(
            .NREQ(NREQ),
            .REQW(REQW)
        ) u_pace (
            .sw_mode    (q.sw),
            .code       (side_code[s]),
            .periph_req (periph_req),
            .ready      (side_ready[s]),
            .ack_sel    (side_ack[s])
        );
    end

    dma_burst_sizer #(
        .CNT_W(WCW)
    ) u_sizer (
        .code        (q.bcode),
        .rem_words   (q.rem),
        .burst_words (next_burst)
    );

    always_comb begin
        ack_all = '0;
        for (int s = 0; s < NSIDES; s++) begin
            ack_all = ack_all | side_ack[s];
        end
        len_ext      = {1'b0, cfg_len} + (LENW+1)'(3);
        launch_words = WCW'(len_ext >> 2);
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.ack  = '0;
        if (abort && (q.st != ST_IDLE)) begin
            d.abort_pend = 1'b1;
        end
        case (q.st)
            ST_IDLE: begin
                d.abort_pend = 1'b0;
                if (launch) begin
                    if (cfg_len == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st    = ST_WAIT;
                        d.src   = cfg_src_addr;
                        d.dst   = cfg_dst_addr;
                        d.rem   = launch_words;
                        d.beat  = '0;
                        d.bcode = cfg_burst;
                        d.sf    = cfg_src_fixed;
                        d.df    = cfg_dst_fixed;
                        d.sw    = cfg_sw_mode;
                        d.sreq  = cfg_src_req;
                        d.dreq  = cfg_dst_req;
                    end
                end
            end
            ST_WAIT: begin
                if (q.abort_pend || abort) begin
                    d.st         = ST_IDLE;
                    d.abort_pend = 1'b0;
                end else if (&side_ready) begin
                    d.beat = next_burst;
                    d.st   = ST_RD;
                end
            end
            ST_RD: begin
                d.st = ST_WR;
            end
            ST_WR: begin
                if (!q.sf) d.src = q.src + AW'(4);
                if (!q.df) d.dst = q.dst + AW'(4);
                d.rem  = q.rem - WCW'(1);
                d.beat = q.beat - BEAT_W'(1);
                if (q.beat == BEAT_W'(1)) begin
                    d.ack = ack_all;
                end
                if (q.rem == WCW'(1)) begin
                    d.st         = ST_IDLE;
                    d.done       = 1'b1;
                    d.abort_pend = 1'b0;
                end else if (q.abort_pend || abort) begin
                    d.st         = ST_IDLE;
                    d.abort_pend = 1'b0;
                end else if (q.beat == BEAT_W'(1)) begin
                    d.st = ST_WAIT;
                end else begin
                    d.st = ST_RD;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.st != ST_IDLE);
    assign done        = q.done;
    assign periph_ack  = q.ack;
    assign mem_rd_en   = (q.st == ST_RD);
    assign mem_rd_addr = q.src;
    assign mem_wr_en   = (q.st == ST_WR);
    assign mem_wr_addr = q.dst;
    assign mem_wr_data = mem_rd_data;
endmodule

// File: rtl/dma_burst_engine_chk.sv
module dma_burst_engine_chk #(
    parameter int NREQ = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            launch,
    input logic            busy,
    input logic            done,
    input logic            mem_rd_en,
    input logic            mem_wr_en,
    input logic [NREQ-1:0] periph_ack
);
    a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    a_r1_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en));

    a_r7_ack_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|periph_ack) |-> $past(mem_wr_en));

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) || $past(launch)));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd_en || mem_wr_en));
endmodule

bind dma_burst_engine dma_burst_engine_chk #(.NREQ(NREQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .busy       (busy),
    .done       (done),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .periph_ack (periph_ack)
);

// File: tb/dma_burst_engine_test.sv
module dma_burst_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int NREQ = 32;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [15:0] len;
        logic [2:0]  bc;
        logic        sf;
        logic        df;
        logic        sw;
        logic [5:0]  sreq;
        logic [5:0]  dreq;
        logic [15:0] exp_words;
        logic [7:0]  exp_bursts;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{32'h000, 32'h200, 16'd40, 3'd2, 1'b0, 1'b0, 1'b1, 6'd32, 6'd32, 16'd10, 8'd0},
        '{32'h040, 32'h3F0, 16'd30, 3'd1, 1'b0, 1'b1, 1'b0, 6'd32, 6'd5,  16'd8,  8'd4},
        '{32'h0F0, 32'h280, 16'd64, 3'd4, 1'b1, 1'b0, 1'b0, 6'd7,  6'd32, 16'd16, 8'd1},
        '{32'h100, 32'h300, 16'd5,  3'd0, 1'b0, 1'b0, 1'b1, 6'd32, 6'd32, 16'd2,  8'd0},
        '{32'h140, 32'h3E0, 16'd36, 3'd3, 1'b0, 1'b1, 1'b0, 6'd32, 6'd3,  16'd9,  8'd2},
        '{32'h180, 32'h340, 16'd72, 3'd7, 1'b0, 1'b0, 1'b0, 6'd9,  6'd32, 16'd18, 8'd2},
        '{32'h1C0, 32'h3D0, 16'd16, 3'd1, 1'b1, 1'b1, 1'b0, 6'd4,  6'd6,  16'd4,  8'd2}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            launch = 1'b0;
    logic            abort = 1'b0;
    logic [31:0]     cfg_src_addr = '0;
    logic [31:0]     cfg_dst_addr = '0;
    logic [15:0]     cfg_len = '0;
    logic [2:0]      cfg_burst = '0;
    logic            cfg_src_fixed = 1'b0;
    logic            cfg_dst_fixed = 1'b0;
    logic            cfg_sw_mode = 1'b0;
    logic [5:0]      cfg_src_req = 6'd32;
    logic [5:0]      cfg_dst_req = 6'd32;
    logic [NREQ-1:0] periph_req = '1;
    logic [NREQ-1:0] periph_ack;
    logic            busy, done;
    logic            mem_rd_en, mem_wr_en;
    logic [31:0]     mem_rd_addr, mem_wr_addr, mem_wr_data;
    logic [31:0]     mem_rd_data = '0;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [256];
    logic        mem_init = 1'b1;
    int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, ack_tot = 0;
    int ack_line [NREQ];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_burst_engine uut (
        .clk(clk), .rst_n(rst_n), .launch(launch), .abort(abort),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr), .cfg_len(cfg_len),
        .cfg_burst(cfg_burst), .cfg_src_fixed(cfg_src_fixed), .cfg_dst_fixed(cfg_dst_fixed),
        .cfg_sw_mode(cfg_sw_mode), .cfg_src_req(cfg_src_req), .cfg_dst_req(cfg_dst_req),
        .periph_req(periph_req), .periph_ack(periph_ack), .busy(busy), .done(done),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    function automatic logic [31:0] pat(input int i);
        return 32'h5A5A0000 + 32'(i * 3 + 1);
    endfunction

    always @(posedge clk) begin
        if (mem_init) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i);
        end else if (mem_wr_en) begin
            mem[mem_wr_addr[9:2]] <= mem_wr_data;
        end
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:2]];
        if (mem_rd_en) rd_cnt <= rd_cnt + 1;
        if (mem_wr_en) wr_cnt <= wr_cnt + 1;
        if (done) done_cnt <= done_cnt + 1;
        ack_tot <= ack_tot + $countones(periph_ack);
        for (int i = 0; i < NREQ; i++) begin
            if (periph_ack[i]) ack_line[i] <= ack_line[i] + 1;
        end
    end

    initial begin
        for (int i = 0; i < NREQ; i++) ack_line[i] = 0;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input vec_t v);
        cfg_src_addr  = v.src;
        cfg_dst_addr  = v.dst;
        cfg_len       = v.len;
        cfg_burst     = v.bc;
        cfg_src_fixed = v.sf;
        cfg_dst_fixed = v.df;
        cfg_sw_mode   = v.sw;
        cfg_src_req   = v.sreq;
        cfg_dst_req   = v.dreq;
    endtask

    task automatic pulse_launch();
        launch = 1'b1;
        @(negedge clk);
        launch = 1'b0;
    endtask

    task automatic wait_done(input int snap);
        for (int t = 0; t < 5000; t++) begin
            if (done_cnt != snap) break;
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int rd0, wr0, dn0, at0, sl0, dl0, nside, bad, sidx;
        rd0 = rd_cnt; wr0 = wr_cnt; dn0 = done_cnt; at0 = ack_tot;
        sl0 = (v.sreq < 32) ? ack_line[v.sreq] : 0;
        dl0 = (v.dreq < 32) ? ack_line[v.dreq] : 0;
        set_cfg(v);
        pulse_launch();
        wait_done(dn0);
        repeat (2) @(negedge clk);
        // R3: word count and no overshoot
        chk(wr_cnt - wr0 == int'(v.exp_words), "R3 writes", wr_cnt - wr0, int'(v.exp_words));
        // R1: one read per written word
        chk(rd_cnt - rd0 == int'(v.exp_words), "R1 reads", rd_cnt - rd0, int'(v.exp_words));
        // R8: single done, busy low
        chk(done_cnt - dn0 == 1 && !busy, "R8 done/busy", done_cnt - dn0, 1);
        // R4 / R1: data and addressing
        sidx = int'(v.src[9:2]);
        bad = 0;
        if (v.df) begin
            if (mem[v.dst[9:2]] != pat(sidx + (v.sf ? 0 : int'(v.exp_words) - 1))) bad = 1;
        end else begin
            for (int j = 0; j < int'(v.exp_words); j++) begin
                if (mem[int'(v.dst[9:2]) + j] != pat(sidx + (v.sf ? 0 : j))) bad++;
            end
        end
        chk(bad == 0, "R4 data/address stepping", bad, 0);
        // R2 / R7: acknowledge count per paced side
        nside = (!v.sw && v.sreq < 32 ? 1 : 0) + (!v.sw && v.dreq < 32 ? 1 : 0);
        chk(ack_tot - at0 == nside * int'(v.exp_bursts), "R2 R7 ack total",
            ack_tot - at0, nside * int'(v.exp_bursts));
        if (!v.sw && v.sreq < 32)
            chk(ack_line[v.sreq] - sl0 == int'(v.exp_bursts), "R7 src ack line",
                ack_line[v.sreq] - sl0, int'(v.exp_bursts));
        if (!v.sw && v.dreq < 32)
            chk(ack_line[v.dreq] - dl0 == int'(v.exp_bursts), "R7 dst ack line",
                ack_line[v.dreq] - dl0, int'(v.exp_bursts));
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int rd0, wr0, dn0, at0;
        vec_t v;
        repeat (3) @(negedge clk);
        mem_init = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(!busy && !done && !mem_rd_en && !mem_wr_en && periph_ack == '0,
            "R12 reset state", int'(busy), 0);

        for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);

        // R10: zero length
        rd0 = rd_cnt; wr0 = wr_cnt;
        v = VECS[0]; v.len = 16'd0;
        set_cfg(v);
        launch = 1'b1;
        @(negedge clk);
        launch = 1'b0;
        chk(done && !busy, "R10 zero-length done next cycle", int'(done), 1);
        @(negedge clk);
        chk(!done, "R10 done one cycle", int'(done), 0);
        repeat (3) @(negedge clk);
        chk(rd_cnt == rd0 && wr_cnt == wr0, "R10 no access", wr_cnt - wr0, 0);

        // R6: paced side stalls while its request is low
        periph_req = '0;
        rd0 = rd_cnt; wr0 = wr_cnt; dn0 = done_cnt;
        v = '{32'h000, 32'h3C0, 16'd8, 3'd0, 1'b0, 1'b1, 1'b0, 6'd32, 6'd2, 16'd2, 8'd2};
        set_cfg(v);
        pulse_launch();
        repeat (20) @(negedge clk);
        chk(rd_cnt == rd0 && busy, "R6 stall without request", rd_cnt - rd0, 0);
        // R9: launch while busy is ignored
        v = '{32'h000, 32'h200, 16'd400, 3'd4, 1'b0, 1'b0, 1'b1, 6'd32, 6'd32, 16'd100, 8'd0};
        set_cfg(v);
        pulse_launch();
        at0 = ack_line[2];
        periph_req[2] = 1'b1;
        wait_done(dn0);
        repeat (50) @(negedge clk);
        chk(wr_cnt - wr0 == 2, "R9 busy launch ignored", wr_cnt - wr0, 2);
        chk(ack_line[2] - at0 == 2, "R7 ack per single-word burst", ack_line[2] - at0, 2);
        chk(!busy && done_cnt - dn0 == 1, "R9 single completion", done_cnt - dn0, 1);

        // R5: software mode ignores request lines
        periph_req = '0;
        wr0 = wr_cnt; dn0 = done_cnt; at0 = ack_tot;
        v = '{32'h000, 32'h200, 16'd8, 3'd1, 1'b0, 1'b0, 1'b1, 6'd3, 6'd4, 16'd2, 8'd0};
        set_cfg(v);
        pulse_launch();
        wait_done(dn0);
        repeat (2) @(negedge clk);
        chk(done_cnt - dn0 == 1 && wr_cnt - wr0 == 2, "R5 sw mode runs freely", wr_cnt - wr0, 2);
        chk(ack_tot == at0, "R5 no ack in sw mode", ack_tot - at0, 0);
        periph_req = '1;

        // R11: abort
        rd0 = rd_cnt; wr0 = wr_cnt; dn0 = done_cnt;
        v = '{32'h000, 32'h200, 16'd400, 3'd4, 1'b0, 1'b0, 1'b1, 6'd32, 6'd32, 16'd100, 8'd0};
        set_cfg(v);
        pulse_launch();
        repeat (15) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        repeat (10) @(negedge clk);
        chk(!busy, "R11 busy cleared", int'(busy), 0);
        chk(done_cnt == dn0, "R11 no done", done_cnt - dn0, 0);
        chk(wr_cnt - wr0 < 100 && wr_cnt - wr0 == rd_cnt - rd0, "R11 stop at word boundary",
            wr_cnt - wr0, rd_cnt - rd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule